// File: doc/BRIEF.md
# Framed Serial Transceiver with Transmit Output-Enable Sequencing

This block is the master side of a synchronous serial link that marks each word with a single-period frame pulse. A parallel word, taken through a valid/ready handshake, is shifted out on the transmit data pin most significant bit first. At the same time, bits arriving on the receive pin are assembled into a parallel word that is presented with a one-cycle strobe. The serial clock is generated locally: its half period is a programmable number of system clocks, and it rests low between transfers.

The transmit pin has a separate output-enable signal so that several transmitters can share one wire. When release mode is on, the enable rises only when the first data bit goes out. It falls either at the falling serial-clock edge in the middle of the last bit or at the rising edge that follows the last bit, as chosen by a second bit. When release mode is off, the pin is always driven. It keeps its last bit between words and moves to the next word's first bit when the frame starts. Word length, release mode and release timing are captured together with each word. A following word can be accepted during the last bit period of the current one, so words run without a gap.

Top module: `fsp_txrx`

## Requirements
- R1: The word length is `cfg_size`+1 bits, so codes 3 to 31 give 4 to 32 bits. Any code below 3 gives 4 bits. `ser_txd` carries bit length-1 first and bit 0 last, and it changes only at rising `ser_clk` edges.
- R2: `ser_clk` is low whenever no transfer is running. While a transfer runs it toggles every `cfg_div` system clocks, with a value of 0 treated as 1, so consecutive rising edges are 2·`cfg_div` clocks apart.
- R3: `ser_frm` is high for exactly one serial-clock period. It rises at the first rising edge of a transfer, and the first data bit starts at the next rising edge.
- R4: With release mode on, `ser_oe` is low during the frame period. It rises at the rising edge that starts the first bit and stays high until at least the last bit period.
- R5: With release mode on and late release off, `ser_oe` falls at the falling `ser_clk` edge inside the last bit period.
- R6: With release mode on and late release on, `ser_oe` stays high through the last bit period and falls at the rising edge that ends it.
- R7: With release mode off, `ser_oe` is high outside reset. Between words `ser_txd` holds the last bit sent, and at the rising edge that raises the frame it takes the next word's first bit.
- R8: `ser_rxd` is sampled at falling `ser_clk` edges, first bit first. At the falling edge of the last bit, `rx_valid` pulses for one clock and `rx_data` holds the word right-aligned, with all bits above the word length at zero.
- R9: At the rising edge that starts the last bit, `in_ready` is high for one clock. A word taken there raises the frame during that last bit period, and its first bit follows the previous word's last bit with no idle period.
- R10: Word length, release mode and late release are captured when the word is accepted. Changing those inputs later does not affect that word.
- R11: During reset, `ser_clk`, `ser_frm`, `ser_txd`, `ser_oe` and `rx_valid` are low. While idle with release mode selected, `ser_oe` stays low.
- R12: `in_ready` is high while idle. An accepted word starts its transfer without any further input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 32 | Word to transmit, right-aligned |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word taken when high together with in_valid |
| cfg_size | input | 5 | Word length minus one |
| cfg_tz | input | 1 | Release transmit pin between words |
| cfg_late | input | 1 | Release at the rising edge after the last bit instead of mid-bit |
| cfg_div | input | DIV_W | Serial-clock half period in system clocks |
| rx_data | output | 32 | Received word, right-aligned |
| rx_valid | output | 1 | One-clock strobe for rx_data |
| ser_clk | output | 1 | Serial clock |
| ser_frm | output | 1 | Frame pulse |
| ser_txd | output | 1 | Transmit data |
| ser_oe | output | 1 | Transmit output enable |
| ser_rxd | input | 1 | Receive data |

## Verification
The table holds single words that cover both release timings, release mode off, the shortest and longest lengths, a length code below the minimum, and divider values including zero. The bench acts as the far end. It decodes every pin at every serial-clock edge, so a word sent in the wrong order, a release one edge early or late, and a misplaced frame each show up as a distinct mismatch. Pairs of back-to-back words with different settings on each side separate settings captured per word from settings read live, and they show whether the next frame can start inside the last bit.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int unsigned FSP_MAXW = 32;
  localparam int unsigned FSP_MINW = 4;
  localparam int unsigned FSP_SZW  = $clog2(FSP_MAXW);
  localparam int unsigned FSP_LENW = $clog2(FSP_MAXW + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_TAIL} fsp_state_e;

  typedef struct packed {
    logic [FSP_MAXW-1:0] word;
    logic [FSP_LENW-1:0] len;
    logic                tz;
    logic                late;
  } fsp_job_t;

  // word length from the size code, clamped at the minimum
  function automatic logic [FSP_LENW-1:0] word_bits(input logic [FSP_SZW-1:0] code);
    if (code < FSP_SZW'(FSP_MINW - 1)) return FSP_LENW'(FSP_MINW);
    return FSP_LENW'(code) + 1'b1;
  endfunction

  // single bit of a word selected by a run-time index
  function automatic logic bit_at(input logic [FSP_MAXW-1:0] w, input logic [FSP_LENW-1:0] idx);
    logic [FSP_MAXW-1:0] t;
    t = w >> idx;
    return t[0];
  endfunction
endpackage

// File: rtl/fsp_sclk_gen.sv
module fsp_sclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] term;
  logic             tick;

  function automatic logic [DIV_W-1:0] half_term(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  assign term     = half_term(div);
  assign tick     = run && (cnt_q >= term);
  assign rise_evt = tick && !sclk;
  assign fall_evt = tick && sclk;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      sclk  <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sclk  <= !sclk;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_edge_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> sclk);
endmodule

// File: rtl/fsp_oe_seq.sv
module fsp_oe_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic tz_pin,
  input  logic start_evt,
  input  logic start_tz,
  input  logic load_evt,
  input  logic lsb_fall,
  input  logic end_rise,
  input  logic cur_tz,
  input  logic cur_late,
  input  logic mid_bits,
  output logic oe
);
  always_ff @(posedge clk) begin
    if (!rst_n)                              oe <= 1'b0;
    else if (idle)                           oe <= !tz_pin;
    else if (start_evt)                      oe <= !start_tz;
    else if (load_evt)                       oe <= 1'b1;
    else if (lsb_fall && cur_tz && !cur_late) oe <= 1'b0;
    else if (end_rise && cur_tz)             oe <= 1'b0;
  end

  p_oe_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mid_bits |-> oe);
  p_oe_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lsb_fall && cur_tz && cur_late) |=> oe);
  p_oe_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && $past(idle) && $past(tz_pin)) |-> !oe);
endmodule

// File: rtl/fsp_rx_deser.sv
module fsp_rx_deser import fsp_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                sample,
  input  logic                last,
  input  logic                rxd,
  output logic [FSP_MAXW-1:0] rx_word,
  output logic                rx_valid
);
  logic [FSP_MAXW-2:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q     <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= last;
      if (clr)         sh_q <= '0;
      else if (sample) sh_q <= {sh_q[FSP_MAXW-3:0], rxd};
      if (last)        rx_word <= {sh_q, rxd};
    end
  end

  p_rxv_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(rx_word));
endmodule

// File: rtl/fsp_txrx.sv
module fsp_txrx import fsp_pkg::*; #(
  parameter int unsigned DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FSP_MAXW-1:0] in_data,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [FSP_SZW-1:0]  cfg_size,
  input  logic                cfg_tz,
  input  logic                cfg_late,
  input  logic [DIV_W-1:0]    cfg_div,
  output logic [FSP_MAXW-1:0] rx_data,
  output logic                rx_valid,
  output logic                ser_clk,
  output logic                ser_frm,
  output logic                ser_txd,
  output logic                ser_oe,
  input  logic                ser_rxd
);
  fsp_state_e          state;
  logic [FSP_LENW-1:0] pos, bidx;
  fsp_job_t            cur, nxt;
  logic                frm_q, txd_q;

  logic rise_evt, fall_evt, run;
  logic idle, in_bits, mid, at_lsb, take;
  logic lead_rise, load_evt, shift_evt, end_rise, sample, lsb_fall;

  assign idle      = (state == ST_IDLE);
  assign run       = !idle;
  assign in_bits   = (state == ST_XFER) && (pos != '0);
  assign mid       = in_bits && (pos < cur.len);
  assign at_lsb    = in_bits && (pos == cur.len);
  assign in_ready  = idle || (rise_evt && mid && (pos == cur.len - 1'b1));
  assign take      = in_valid && in_ready;
  assign lead_rise = rise_evt && (state == ST_LEAD);
  assign load_evt  = rise_evt && (state == ST_XFER) && ((pos == '0) || (at_lsb && frm_q));
  assign shift_evt = rise_evt && mid;
  assign end_rise  = rise_evt && at_lsb && !frm_q;
  assign sample    = fall_evt && in_bits;
  assign lsb_fall  = fall_evt && at_lsb;

  fsp_sclk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .div(cfg_div),
    .sclk(ser_clk), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  fsp_oe_seq u_oe (
    .clk(clk), .rst_n(rst_n), .idle(idle), .tz_pin(cfg_tz),
    .start_evt(lead_rise), .start_tz(nxt.tz), .load_evt(load_evt),
    .lsb_fall(lsb_fall), .end_rise(end_rise), .cur_tz(cur.tz),
    .cur_late(cur.late), .mid_bits(mid), .oe(ser_oe)
  );

  fsp_rx_deser u_rx (
    .clk(clk), .rst_n(rst_n), .clr(load_evt), .sample(sample),
    .last(lsb_fall), .rxd(ser_rxd), .rx_word(rx_data), .rx_valid(rx_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pos   <= '0;
      bidx  <= '0;
      cur   <= '0;
      nxt   <= '0;
      frm_q <= 1'b0;
      txd_q <= 1'b0;
    end else begin
      if (take) begin
        nxt.word <= in_data;
        nxt.len  <= word_bits(cfg_size);
        nxt.tz   <= cfg_tz;
        nxt.late <= cfg_late;
      end
      unique case (state)
        ST_IDLE: if (take) state <= ST_LEAD;
        ST_LEAD: if (rise_evt) begin
          frm_q <= 1'b1;
          pos   <= '0;
          txd_q <= bit_at(nxt.word, nxt.len - 1'b1);
          state <= ST_XFER;
        end
        ST_XFER: begin
          if (load_evt) begin
            frm_q <= 1'b0;
            cur   <= nxt;
            pos   <= FSP_LENW'(1);
            bidx  <= nxt.len - 1'b1;
            txd_q <= bit_at(nxt.word, nxt.len - 1'b1);
          end else if (shift_evt) begin
            pos   <= pos + 1'b1;
            bidx  <= bidx - 1'b1;
            txd_q <= bit_at(cur.word, bidx - 1'b1);
            if (take) frm_q <= 1'b1;
          end else if (end_rise) begin
            state <= ST_TAIL;
          end
        end
        ST_TAIL: if (fall_evt) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ser_frm = frm_q;
  assign ser_txd = txd_q;

  p_frame_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_q && rise_evt) |=> !frm_q);
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !ser_clk);
  p_txd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> $stable(txd_q));
  p_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && in_valid) |=> (state == ST_LEAD));
endmodule

// File: tb/sim_fsp_txrx.sv
module sim_fsp_txrx;
  localparam int DIV_W = 8;

  typedef struct packed {
    logic [31:0] d;
    logic [4:0]  sz;
    logic        tz;
    logic        lt;
    logic [3:0]  dv;
    logic [31:0] rx;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_000A, 5'd3,  1'b1, 1'b0, 4'd1, 32'h0000_0005},
    '{32'h0000_00A5, 5'd7,  1'b1, 1'b1, 4'd2, 32'h0000_003C},
    '{32'h1234_5678, 5'd31, 1'b0, 1'b0, 4'd1, 32'hDEAD_BEEF},
    '{32'h0000_1FFF, 5'd12, 1'b1, 1'b1, 4'd3, 32'h0000_0AAA},
    '{32'hF0F0_0005, 5'd2,  1'b1, 1'b0, 4'd0, 32'hFFFF_FFF9},
    '{32'h0000_8001, 5'd15, 1'b0, 1'b1, 4'd2, 32'h0000_7FFE}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] in_data = '0;
  logic in_valid = 1'b0, in_ready;
  logic [4:0] cfg_size = '0;
  logic cfg_tz = 1'b1, cfg_late = 1'b0;
  logic [DIV_W-1:0] cfg_div = 8'd1;
  logic [31:0] rx_data;
  logic rx_valid, ser_clk, ser_frm, ser_txd, ser_oe;
  logic ser_rxd = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [31:0] wd [2], wrx [2];
  logic [4:0]  wsz [2];
  int          wl [2];
  bit          wt [2], wlt [2];

  always #4 clk = ~clk;

  fsp_txrx #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .cfg_size(cfg_size), .cfg_tz(cfg_tz),
    .cfg_late(cfg_late), .cfg_div(cfg_div), .rx_data(rx_data),
    .rx_valid(rx_valid), .ser_clk(ser_clk), .ser_frm(ser_frm),
    .ser_txd(ser_txd), .ser_oe(ser_oe), .ser_rxd(ser_rxd)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int len_of(input logic [4:0] sz);
    int n;
    n = int'(sz) + 1;
    return (n < 4) ? 4 : n;
  endfunction

  function automatic logic [31:0] keep_low(input logic [31:0] v, input int n);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < n; b++) r[b] = v[b];
    return r;
  endfunction

  task automatic set_word(input int k);
    in_data  = wd[k];
    cfg_size = wsz[k];
    cfg_tz   = wt[k];
    cfg_late = wlt[k];
  endtask

  task automatic run_xfer(input int nw);
    int r, cyc, last_rise, f2, e, acc, k, i, hd, l0, l1;
    bit pend, prev, done, s, efrm;
    r = 0; cyc = 0; last_rise = 0; acc = 0; pend = 0; done = 0;
    hd = (cfg_div == 0) ? 1 : int'(cfg_div);
    f2 = wl[0] + 1;
    l0 = wl[0] + 1;
    l1 = f2 + wl[1];
    e  = (nw == 2) ? wl[0] + wl[1] + 2 : wl[0] + 2;
    @(negedge clk);
    set_word(0);
    in_valid = 1'b1;
    prev = ser_clk;
    while (!done) begin
      if (in_valid && in_ready) pend = 1;
      @(negedge clk);
      cyc++;
      if (pend) begin
        pend = 0;
        acc++;
        if (acc < nw) set_word(acc);
        else in_valid = 1'b0;
      end
      s = ser_clk;
      if (s && !prev) begin
        r++;
        efrm = (r == 1) || (nw == 2 && r == f2);
        chk(ser_frm == efrm, "R3 frame", ser_frm, efrm);
        if (r >= 2) chk(cyc - last_rise == 2 * hd, "R2 period", cyc - last_rise, 2 * hd);
        last_rise = cyc;
        if (nw == 2 && r == f2) chk(acc == 2, "R9 accept in last bit", acc, 2);
        if (r == 1) begin
          chk(ser_txd == wd[0][wl[0]-1], "R7 msb at frame", ser_txd, wd[0][wl[0]-1]);
          chk(ser_oe == !wt[0], "R4 oe in frame", ser_oe, !wt[0]);
        end else if (r == e) begin
          chk(ser_oe == !wt[nw-1], "R6 oe after last bit", ser_oe, !wt[nw-1]);
          chk(ser_txd == wd[nw-1][0], "R7 hold last bit", ser_txd, wd[nw-1][0]);
        end else begin
          k = (r <= l0) ? 0 : 1;
          i = (k == 0) ? wl[0] - 1 - (r - 2) : wl[1] - 1 - (r - f2 - 1);
          chk(ser_txd == wd[k][i], "R1 data bit", ser_txd, wd[k][i]);
          chk(ser_oe == 1'b1, "R4 oe during bits", ser_oe, 1);
          ser_rxd = wrx[k][i];
        end
      end else if (!s && prev) begin
        if (r == l0 || (nw == 2 && r == l1)) begin
          k = (r == l0) ? 0 : 1;
          chk(rx_valid == 1'b1, "R8 strobe", rx_valid, 1);
          chk(rx_data == keep_low(wrx[k], wl[k]), "R8 word", rx_data, keep_low(wrx[k], wl[k]));
          if (wt[k] && !wlt[k]) chk(ser_oe == 1'b0, "R5 mid-bit release", ser_oe, 0);
          else chk(ser_oe == 1'b1, "R6 held through last bit", ser_oe, 1);
          if (nw == 2 && k == 0) chk(ser_oe == !(wt[0] && !wlt[0]), "R10 own setting", ser_oe, !(wt[0] && !wlt[0]));
        end else begin
          chk(rx_valid == 1'b0, "R8 no strobe", rx_valid, 0);
        end
        if (r == e) done = 1;
      end
      prev = s;
      if (cyc > 5000) begin
        chk(1'b0, "R12 transfer stalled", r, e);
        done = 1;
      end
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 values held in reset
    chk(ser_clk == 0, "R11 sclk", ser_clk, 0);
    chk(ser_frm == 0, "R11 frame", ser_frm, 0);
    chk(ser_txd == 0, "R11 txd", ser_txd, 0);
    chk(ser_oe == 0, "R11 oe", ser_oe, 0);
    chk(rx_valid == 0, "R11 strobe", rx_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ser_oe == 0, "R11 idle released", ser_oe, 0);
    chk(in_ready == 1, "R12 ready idle", in_ready, 1);
    cfg_tz = 1'b0;
    repeat (2) @(negedge clk);
    chk(ser_oe == 1, "R7 idle driven", ser_oe, 1);

    for (int v = 0; v < 6; v++) begin
      cfg_div = DIV_W'(VECS[v].dv);
      wd[0] = VECS[v].d; wsz[0] = VECS[v].sz; wl[0] = len_of(VECS[v].sz);
      wt[0] = VECS[v].tz; wlt[0] = VECS[v].lt; wrx[0] = VECS[v].rx;
      run_xfer(1);
      repeat (3) @(negedge clk);
      chk(ser_clk == 0, "R2 idle low", ser_clk, 0);
      chk(ser_oe == !cfg_tz, "R7 idle oe", ser_oe, !cfg_tz);
      chk(ser_txd == wd[0][0], "R7 idle holds last bit", ser_txd, wd[0][0]);
    end

    // back-to-back: early then late release, different lengths
    cfg_div = 8'd2;
    wd[0] = 32'h0000_005A; wsz[0] = 5'd7;  wl[0] = 8;  wt[0] = 1; wlt[0] = 0; wrx[0] = 32'h0000_00C3;
    wd[1] = 32'h0000_03F0; wsz[1] = 5'd11; wl[1] = 12; wt[1] = 1; wlt[1] = 1; wrx[1] = 32'h0000_0ABC;
    run_xfer(2);
    repeat (4) @(negedge clk);

    // back-to-back: late release then driven, divider 1
    cfg_div = 8'd1;
    wd[0] = 32'h0000_0009; wsz[0] = 5'd3;  wl[0] = 4;  wt[0] = 1; wlt[0] = 1; wrx[0] = 32'h0000_0006;
    wd[1] = 32'hC000_0003; wsz[1] = 5'd31; wl[1] = 32; wt[1] = 0; wlt[1] = 0; wrx[1] = 32'h8765_4321;
    run_xfer(2);
    repeat (4) @(negedge clk);
    chk(ser_oe == 1, "R7 idle after driven word", ser_oe, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule